// File: doc/BRIEF.md
# Pending Interrupt Source Resolver

The resolver sits between the pending-status logic of an interrupt controller and the processor's dispatch path. Each cycle it takes a 21-bit summary word and the two 32-bit bank words, which already carry enable masking. It then picks the one source to be serviced next. The result is a valid flag and a 7-bit flat source number, both registered one clock after the inputs. Flat numbering runs 0..7 for the basic sources, 8..39 for bank 1 and 40..71 for bank 2.

The search order has four stages. The basic sources are scanned first. Next come the shortcut bits that the summary word copies from a few bank positions. The full bank words are scanned last, with the shortcut positions removed. This order lets the common sources be found from the summary alone.

A second, independent port converts a (bank, index) descriptor into a flat source number and flags descriptors that fall out of range. This lets configuration logic reuse the same numbering. Its result is also registered one clock later.

Top module: `irq_resolve_top`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears id_valid_o and id_o to 0. Outside reset, both resolver outputs reflect the inputs sampled at the previous rising clock edge.
- R2: When summary_i[20:0] is all zero, id_valid_o is 0. Whenever id_valid_o is 0, id_o is 0.
- R3: If any of summary_i[7:0] is set, the result is valid and id_o is the lowest set position among those bits.
- R4: Otherwise, summary_i bits 10,11,12,13,14 stand for bank-1 indices 7,9,10,18,19. The lowest set summary bit among them wins, and id_o = 8 + its bank index.
- R5: Otherwise, summary_i bits 15..20 stand for bank-2 indices 21,22,23,24,25,30. The lowest set summary bit wins, and id_o = 40 + its bank index.
- R6: Otherwise, if summary_i[8] is set, bank1_i is searched with bits 7,9,10,18,19 forced to zero. The lowest remaining set bit k gives id_o = 8 + k.
- R7: Otherwise, if summary_i[9] is set, bank2_i is searched with bits 21..25 and 30 forced to zero. The lowest remaining set bit k gives id_o = 40 + k. If no stage yields a source, id_valid_o is 0.
- R8: A bank word has no effect on the result while its summary flag (bit 8 for bank 1, bit 9 for bank 2) is clear.
- R9: The translation port maps xl_bank_i=0 to xl_index_i, valid only if the index is below 8. It maps bank 1 to index+8, valid only up to 39. It maps bank 2 to index+40, valid only up to 71. When the descriptor is invalid, xl_id_o is 0.
- R10: xl_bank_i=3 always gives xl_valid_o=0.
- R11: Translation outputs appear one clock after the descriptor is sampled, and reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| summary_i | input | 21 | Summary word: basic sources, bank flags, shortcut bits |
| bank1_i | input | 32 | Masked bank-1 pending word |
| bank2_i | input | 32 | Masked bank-2 pending word |
| id_valid_o | output | 1 | A source is selected |
| id_o | output | 7 | Flat number of the selected source |
| xl_bank_i | input | 2 | Descriptor bank selector |
| xl_index_i | input | 8 | Descriptor index within the bank |
| xl_valid_o | output | 1 | Descriptor is in range |
| xl_id_o | output | 7 | Flat number for the descriptor |

## Verification
The directed cases target the priority seams. When a basic bit and shortcuts are both set, a design with the wrong stage order returns a bank number. When several shortcuts are set, a reversed scan picks index 19 instead of 10. When a bank word holds only shortcut positions, a missing exclusion mask reports a duplicate source where none should be valid. When the bank-1 flag is set but its masked word is empty, a design that stops there never reaches bank 2. The translation cases sit on each bank's last legal index and one past it, where an off-by-one limit accepts 8, 40 or 72. The latency case catches an output that shows up combinationally or a cycle late.

// File: rtl/irq_resolve_pkg.sv
package irq_resolve_pkg;

  localparam int BASIC_N = 8;
  localparam int BANK_W  = 32;
  localparam int SC1_N   = 5;
  localparam int SC2_N   = 6;

  localparam int SC1_POS [SC1_N] = '{7, 9, 10, 18, 19};
  localparam int SC2_POS [SC2_N] = '{21, 22, 23, 24, 25, 30};

  localparam int FLAG1_BIT  = BASIC_N;
  localparam int FLAG2_BIT  = BASIC_N + 1;
  localparam int SC1_LSB    = BASIC_N + 2;
  localparam int SC2_LSB    = SC1_LSB + SC1_N;
  localparam int SUM_W      = SC2_LSB + SC2_N;

  localparam int BANK1_BASE = BASIC_N;
  localparam int BANK2_BASE = BASIC_N + BANK_W;
  localparam int SRC_N      = BANK2_BASE + BANK_W;
  localparam int ID_W       = $clog2(SRC_N);
  localparam int IDX_W      = 8;

  function automatic logic [BANK_W-1:0] sc1_mask();
    logic [BANK_W-1:0] m;
    m = '0;
    for (int i = 0; i < SC1_N; i++) m[SC1_POS[i]] = 1'b1;
    return m;
  endfunction

  function automatic logic [BANK_W-1:0] sc2_mask();
    logic [BANK_W-1:0] m;
    m = '0;
    for (int i = 0; i < SC2_N; i++) m[SC2_POS[i]] = 1'b1;
    return m;
  endfunction

  function automatic int sc1_lookup(input int k);
    int r;
    r = 0;
    for (int i = 0; i < SC1_N; i++) if (i == k) r = SC1_POS[i];
    return r;
  endfunction

  function automatic int sc2_lookup(input int k);
    int r;
    r = 0;
    for (int i = 0; i < SC2_N; i++) if (i == k) r = SC2_POS[i];
    return r;
  endfunction

endpackage

// File: rtl/irq_lsb_pick.sv
module irq_lsb_pick #(
  parameter  int W  = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);

  always_comb begin
    hit_o = |req_i;
    idx_o = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (req_i[k]) idx_o = IW'(k);
    end
  end

endmodule

// File: rtl/irq_xlat.sv
module irq_xlat
  import irq_resolve_pkg::*;
(
  input  logic [1:0]       bank_i,
  input  logic [IDX_W-1:0] index_i,
  output logic             ok_o,
  output logic [ID_W-1:0]  id_o
);

  localparam int SUM_BITS = IDX_W + 2;

  logic [SUM_BITS-1:0] flat;

  always_comb begin
    ok_o = 1'b0;
    flat = '0;
    unique case (bank_i)
      2'd0: begin
        flat = SUM_BITS'(index_i);
        ok_o = (flat < SUM_BITS'(BASIC_N));
      end
      2'd1: begin
        flat = SUM_BITS'(index_i) + SUM_BITS'(BANK1_BASE);
        ok_o = (flat <= SUM_BITS'(BANK1_BASE + BANK_W - 1));
      end
      2'd2: begin
        flat = SUM_BITS'(index_i) + SUM_BITS'(BANK2_BASE);
        ok_o = (flat <= SUM_BITS'(BANK2_BASE + BANK_W - 1));
      end
      default: ok_o = 1'b0;
    endcase
    id_o = ok_o ? flat[ID_W-1:0] : '0;
  end

endmodule

// File: rtl/irq_resolve_top.sv
module irq_resolve_top
  import irq_resolve_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SUM_W-1:0]  summary_i,
  input  logic [BANK_W-1:0] bank1_i,
  input  logic [BANK_W-1:0] bank2_i,
  output logic              id_valid_o,
  output logic [ID_W-1:0]   id_o,
  input  logic [1:0]        xl_bank_i,
  input  logic [IDX_W-1:0]  xl_index_i,
  output logic              xl_valid_o,
  output logic [ID_W-1:0]   xl_id_o
);

  localparam logic [BANK_W-1:0] SC1_MASK = sc1_mask();
  localparam logic [BANK_W-1:0] SC2_MASK = sc2_mask();
  localparam int BIW  = $clog2(BASIC_N);
  localparam int S1W  = $clog2(SC1_N);
  localparam int S2W  = $clog2(SC2_N);
  localparam int WIW  = $clog2(BANK_W);

  // stage hit detectors
  logic           basic_hit, sc1_hit, sc2_hit, w1_hit, w2_hit;
  logic [BIW-1:0] basic_idx;
  logic [S1W-1:0] sc1_idx;
  logic [S2W-1:0] sc2_idx;
  logic [WIW-1:0] w1_idx, w2_idx;
  logic [BANK_W-1:0] w1_req, w2_req;

  assign w1_req = summary_i[FLAG1_BIT] ? (bank1_i & ~SC1_MASK) : '0;
  assign w2_req = summary_i[FLAG2_BIT] ? (bank2_i & ~SC2_MASK) : '0;

  irq_lsb_pick #(.W(BASIC_N)) u_basic (
    .req_i(summary_i[BASIC_N-1:0]), .hit_o(basic_hit), .idx_o(basic_idx));
  irq_lsb_pick #(.W(SC1_N)) u_sc1 (
    .req_i(summary_i[SC1_LSB +: SC1_N]), .hit_o(sc1_hit), .idx_o(sc1_idx));
  irq_lsb_pick #(.W(SC2_N)) u_sc2 (
    .req_i(summary_i[SC2_LSB +: SC2_N]), .hit_o(sc2_hit), .idx_o(sc2_idx));
  irq_lsb_pick #(.W(BANK_W)) u_w1 (
    .req_i(w1_req), .hit_o(w1_hit), .idx_o(w1_idx));
  irq_lsb_pick #(.W(BANK_W)) u_w2 (
    .req_i(w2_req), .hit_o(w2_hit), .idx_o(w2_idx));

  // next state: stage priority chain
  logic            valid_d, valid_q;
  logic [ID_W-1:0] id_d, id_q;

  always_comb begin
    valid_d = 1'b1;
    id_d    = '0;
    if (basic_hit) begin
      id_d = ID_W'(basic_idx);
    end else if (sc1_hit) begin
      id_d = ID_W'(BANK1_BASE + sc1_lookup(int'(sc1_idx)));
    end else if (sc2_hit) begin
      id_d = ID_W'(BANK2_BASE + sc2_lookup(int'(sc2_idx)));
    end else if (w1_hit) begin
      id_d = ID_W'(BANK1_BASE + int'(w1_idx));
    end else if (w2_hit) begin
      id_d = ID_W'(BANK2_BASE + int'(w2_idx));
    end else begin
      valid_d = 1'b0;
    end
  end

  // translation port
  logic            xv_d, xv_q;
  logic [ID_W-1:0] xid_d, xid_q;

  irq_xlat u_xlat (
    .bank_i(xl_bank_i), .index_i(xl_index_i), .ok_o(xv_d), .id_o(xid_d));

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      id_q    <= '0;
      xv_q    <= 1'b0;
      xid_q   <= '0;
    end else begin
      valid_q <= valid_d;
      id_q    <= id_d;
      xv_q    <= xv_d;
      xid_q   <= xid_d;
    end
  end

  assign id_valid_o = valid_q;
  assign id_o       = id_q;
  assign xl_valid_o = xv_q;
  assign xl_id_o    = xid_q;

  // checks
  AST_IDLE_ID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid_o |-> id_o == '0); // R2
  AST_EMPTY_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    summary_i == '0 |=> !id_valid_o); // R2
  AST_BASIC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|summary_i[BASIC_N-1:0]) |=> id_valid_o && id_o < ID_W'(BASIC_N)); // R3
  AST_SC1_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (summary_i[BASIC_N-1:0] == '0 && |summary_i[SC1_LSB +: SC1_N])
      |=> id_valid_o && id_o >= ID_W'(BANK1_BASE) && id_o < ID_W'(BANK2_BASE)); // R4
  AST_SC2_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (summary_i[BASIC_N-1:0] == '0 && summary_i[SC1_LSB +: SC1_N] == '0
      && |summary_i[SC2_LSB +: SC2_N]) |=> id_valid_o && id_o >= ID_W'(BANK2_BASE)); // R5
  AST_ID_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid_o |-> id_o < ID_W'(SRC_N)); // R7
  AST_XL_BANK3: assert property (@(posedge clk) disable iff (!rst_n)
    xl_bank_i == 2'd3 |=> !xl_valid_o); // R10
  AST_XL_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_valid_o |-> xl_id_o == '0); // R9

endmodule

// File: tb/irq_resolve_top_tb_top.sv
module irq_resolve_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [20:0] summary;
  logic [31:0] b1, b2;
  logic        idv, xlv;
  logic [6:0]  id, xlid;
  logic [1:0]  xb;
  logic [7:0]  xi;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_resolve_top dut_i (
    .clk(clk), .rst_n(rst_n), .summary_i(summary), .bank1_i(b1), .bank2_i(b2),
    .id_valid_o(idv), .id_o(id), .xl_bank_i(xb), .xl_index_i(xi),
    .xl_valid_o(xlv), .xl_id_o(xlid));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_res(input string tag, input logic [20:0] s,
                         input logic [31:0] w1, input logic [31:0] w2,
                         input int ev, input int eid);
    summary = s; b1 = w1; b2 = w2;
    @(negedge clk);
    chk({tag, " valid"}, int'(idv), ev);
    chk({tag, " id"}, int'(id), eid);
  endtask

  task automatic run_xl(input string tag, input logic [1:0] bk,
                        input logic [7:0] ix, input int ev, input int eid);
    xb = bk; xi = ix;
    @(negedge clk);
    chk({tag, " valid"}, int'(xlv), ev);
    chk({tag, " id"}, int'(xlid), eid);
  endtask

  task automatic t_reset();
    chk("R1 reset valid", int'(idv), 0);
    chk("R1 reset id", int'(id), 0);
    chk("R11 reset xl valid", int'(xlv), 0);
  endtask

  task automatic t_empty();
    run_res("R2 empty summary", 21'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
  endtask

  task automatic t_basic();
    run_res("R3 basic lowest", 21'h0000A0 | 21'h000400, 32'h0, 32'h0, 1, 5);
    run_res("R3 basic over all", 21'h1FFFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0);
  endtask

  task automatic t_sc1();
    run_res("R4 shortcut order", (21'd1 << 12) | (21'd1 << 14) | (21'd1 << 15),
            32'h0, 32'h0, 1, 18);
    run_res("R4 shortcut beats word", (21'd1 << 14) | (21'd1 << 8),
            32'h1, 32'h0, 1, 27);
  endtask

  task automatic t_sc2();
    run_res("R5 shortcut 30", 21'd1 << 20, 32'h0, 32'h0, 1, 70);
    run_res("R5 shortcut order", (21'd1 << 17) | (21'd1 << 19) | (21'd1 << 9),
            32'h0, 32'h1, 1, 63);
  endtask

  task automatic t_word1();
    run_res("R6 masked search", 21'd1 << 8, (32'd1 << 7) | (32'd1 << 9) | (32'd1 << 12),
            32'h0, 1, 20);
    run_res("R6 only shortcut pos", 21'd1 << 8, (32'd1 << 7) | (32'd1 << 19),
            32'h0, 0, 0);
    run_res("R7 fall through to bank2", (21'd1 << 8) | (21'd1 << 9), 32'd1 << 18,
            (32'd1 << 21) | (32'd1 << 31), 1, 71);
  endtask

  task automatic t_word2();
    run_res("R7 bank2 bit0", 21'd1 << 9, 32'h0, 32'h1, 1, 40);
    run_res("R7 nothing remains", 21'd1 << 9, 32'h0, 32'h43E0_0000, 0, 0);
  endtask

  task automatic t_flags();
    run_res("R8 bank1 ignored", 21'd1 << 9, 32'h1, 32'd1 << 3, 1, 43);
    run_res("R8 bank2 ignored", 21'd1 << 8, 32'h0, 32'h1, 0, 0);
  endtask

  task automatic t_xlat();
    run_xl("R9 bank0 max", 2'd0, 8'd7, 1, 7);
    run_xl("R9 bank0 over", 2'd0, 8'd8, 0, 0);
    run_xl("R9 bank1 max", 2'd1, 8'd31, 1, 39);
    run_xl("R9 bank1 over", 2'd1, 8'd32, 0, 0);
    run_xl("R9 bank2 base", 2'd2, 8'd0, 1, 40);
    run_xl("R9 bank2 max", 2'd2, 8'd31, 1, 71);
    run_xl("R9 bank2 over", 2'd2, 8'd32, 0, 0);
    run_xl("R10 bank3", 2'd3, 8'd0, 0, 0);
  endtask

  task automatic t_latency();
    // previous outputs: resolver id 0 invalid, xl invalid
    summary = 21'd1 << 2; b1 = '0; b2 = '0; xb = 2'd1; xi = 8'd3;
    #1;
    chk("R1 no early change", int'(idv), 0);
    chk("R11 no early change", int'(xlv), 0);
    @(negedge clk);
    chk("R1 one cycle id", int'(id), 2);
    chk("R11 one cycle xl id", int'(xlid), 11);
  endtask

  task automatic t_reset_mid();
    rst_n = 1'b0;
    #1;
    chk("R1 async clear valid", int'(idv), 0);
    chk("R1 async clear id", int'(id), 0);
    chk("R11 async clear xl", int'(xlv), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_res("R1 after reset", 21'd1 << 6, 32'h0, 32'h0, 1, 6);
  endtask

  initial begin
    rst_n = 1'b0; summary = '0; b1 = '0; b2 = '0; xb = '0; xi = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_empty();
    t_basic();
    t_sc1();
    t_sc2();
    t_word1();
    t_word2();
    t_flags();
    t_xlat();
    run_res("R2 idle before latency", 21'h0, 32'h0, 32'h0, 0, 0);
    xb = 2'd3; xi = 8'd0;
    @(negedge clk);
    t_latency();
    t_reset_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule